// File: doc/BRIEF.md
# Banked Work RAM Address Mapper

This block sits between a CPU's 16-bit address bus and a 32 KiB work RAM organised as eight banks of 4 KiB. It turns each CPU access that falls inside the work RAM window into a 15-bit physical RAM address with select and write-enable strobes. The first 4 KiB of the window always reaches physical bank 0. The second 4 KiB reaches whichever bank the bank-select register names, and a stored zero is steered to bank one. The top part of the window, from 0xE000 up, is an echo: the address is cut to its low 13 bits, so it maps exactly like the copy 0x2000 below it.

The mapper also holds a 127-byte high RAM internally, plus the 3-bit bank-select register at one fixed I/O address. Every read returns its data one clock after the read strobe. Work RAM data comes back on a return port from an external synchronous RAM. Any address the mapper does not decode reads as 0xFF and never selects the RAM.

Top module: `banked_wram_mapper`

## Requirements
- R1: After reset the bank-select register holds 0. A read of 0xFF70 returns 0x00, and accesses to the switchable half (reduced offset bit 12 = 1) go to physical bank 1.
- R2: A read or write to any address from 0xC000 to 0xFDFF asserts `wram_sel` in the same cycle. `wram_we` is high only for writes, and `wram_wdata` equals `cpu_wdata`.
- R3: When address bit 12 is 0 inside the window, `wram_addr` is {3'b000, cpu_addr[11:0]}.
- R4: When address bit 12 is 1 inside the window, `wram_addr` is {bank, cpu_addr[11:0]}, where bank is the value held in the bank-select register.
- R5: A bank-select value of 0 maps the switchable half to bank 1, never to bank 0.
- R6: Addresses 0xE000 to 0xFDFF give the same `wram_addr` as the same address minus 0x2000.
- R7: A write to 0xFF70 stores `cpu_wdata[2:0]`. A later read of 0xFF70 returns {5'b00000, stored value}, including the value 0.
- R8: Addresses 0xFF80 to 0xFFFE reach an internal 127-byte high RAM indexed by `cpu_addr[6:0]`. Written bytes read back, and these accesses leave `wram_sel` low.
- R9: A read of any address outside the work RAM window, the high RAM range and 0xFF70 returns 0xFF and leaves `wram_sel` low. Writes to such addresses change no stored state.
- R10: `cpu_rdata` carries the result of a read in the clock cycle after the cycle in which `cpu_rd` was high. For work RAM this is `wram_rdata` as returned by the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| wram_addr | output | 15 | Physical work RAM byte address |
| wram_sel | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| wram_wdata | output | 8 | Work RAM write data |
| wram_rdata | input | 8 | Work RAM read data, one cycle after select |

## Verification
A table of addresses is run under several bank values. It covers the fixed and switchable halves, the echo copies of both halves, the last byte of the window and addresses just outside it. This separates a wrong bank field from a wrong offset fold. Bank value 0 is tried against both bank 1 and bank 7 to show that the substitution applies only to zero. Stored bytes are written through an echo address and read back through its primary address, and the reverse. This ties the address mapping to the data path and to the one-cycle read latency. High RAM, the bank register readback with junk in the upper bits, and writes and reads to unmapped addresses are tested as directed cases.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;
  localparam int CPU_AW  = 16;
  localparam int DATA_W  = 8;
  localparam int BANK_W  = 3;
  localparam int OFS_W   = 12;
  localparam int PHYS_W  = BANK_W + OFS_W;
  localparam int HRAM_AW = 7;
  localparam int HRAM_DEPTH = 127;

  localparam logic [CPU_AW-1:0] WIN_LO    = 16'hC000;
  localparam logic [CPU_AW-1:0] WIN_HI    = 16'hFDFF;
  localparam logic [CPU_AW-1:0] HRAM_LO   = 16'hFF80;
  localparam logic [CPU_AW-1:0] HRAM_HI   = 16'hFFFE;
  localparam logic [CPU_AW-1:0] BANK_ADDR = 16'hFF70;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_WRAM = 2'd1,
    RGN_HRAM = 2'd2,
    RGN_BANK = 2'd3
  } region_e;
endpackage

// File: rtl/wram_addr_decode.sv
module wram_addr_decode
  import wram_map_pkg::*;
#(
  parameter int AW     = CPU_AW,
  parameter int BW     = BANK_W,
  parameter int OW     = OFS_W,
  localparam int PW    = BW + OW
) (
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank_q,
  output region_e       region,
  output logic [PW-1:0] phys
);
  logic [OW:0]   reduced;
  logic [BW-1:0] eff_bank;

  always_comb begin
    if (addr >= WIN_LO && addr <= WIN_HI)
      region = RGN_WRAM;
    else if (addr >= HRAM_LO && addr <= HRAM_HI)
      region = RGN_HRAM;
    else if (addr == BANK_ADDR)
      region = RGN_BANK;
    else
      region = RGN_NONE;
  end

  // Fold the echo region onto the primary window, then pick the bank.
  always_comb begin
    reduced  = addr[OW:0];
    eff_bank = (bank_q == '0) ? BW'(1) : bank_q;
    if (reduced[OW])
      phys = {eff_bank, reduced[OW-1:0]};
    else
      phys = {{BW{1'b0}}, reduced[OW-1:0]};
  end
endmodule

// File: rtl/wram_bank_reg.sv
module wram_bank_reg #(
  parameter int BW = wram_map_pkg::BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] bank_q
);
  logic [BW-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (we)
      bank_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bank_q <= '0;
    else
      bank_q <= bank_d;
  end
endmodule

// File: rtl/wram_hram.sv
module wram_hram #(
  parameter int DEPTH = wram_map_pkg::HRAM_DEPTH,
  parameter int IW    = wram_map_pkg::HRAM_AW,
  parameter int DW    = wram_map_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_range;
  logic [DW-1:0] rdata_d;

  always_comb begin
    in_range = (int'(idx) < DEPTH);
    rdata_d  = rdata;
    if (re && in_range)
      rdata_d = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (we && in_range)
      mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= rdata_d;
  end
endmodule

// File: rtl/banked_wram_mapper.sv
module banked_wram_mapper
  import wram_map_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int DW = DATA_W,
  parameter int BW = BANK_W,
  parameter int OW = OFS_W,
  localparam int PW = BW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [DW-1:0] cpu_rdata,
  output logic [PW-1:0] wram_addr,
  output logic          wram_sel,
  output logic          wram_we,
  output logic [DW-1:0] wram_wdata,
  input  logic [DW-1:0] wram_rdata
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  region_e       region;
  logic [BW-1:0] bank_q;
  logic [DW-1:0] hram_rdata;
  logic          access;

  wram_addr_decode #(.AW(AW), .BW(BW), .OW(OW)) u_dec (
    .addr   (cpu_addr),
    .bank_q (bank_q),
    .region (region),
    .phys   (wram_addr)
  );

  wram_bank_reg #(.BW(BW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cpu_wr && region == RGN_BANK),
    .wdata  (cpu_wdata[BW-1:0]),
    .bank_q (bank_q)
  );

  wram_hram #(.DEPTH(HRAM_DEPTH), .IW(HRAM_AW), .DW(DW)) u_hram (
    .clk   (clk),
    .we    (cpu_wr && region == RGN_HRAM),
    .re    (cpu_rd && region == RGN_HRAM),
    .idx   (cpu_addr[HRAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (hram_rdata)
  );

  always_comb begin
    access     = cpu_rd || cpu_wr;
    wram_sel   = access && (region == RGN_WRAM);
    wram_we    = cpu_wr && (region == RGN_WRAM);
    wram_wdata = cpu_wdata;
  end

  // Read return: remember the source of the last read plus a hold byte.
  region_e       src_q, src_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    src_d  = src_q;
    hold_d = hold_q;
    if (cpu_rd) begin
      src_d = region;
      if (region == RGN_BANK)
        hold_d = {{(DW-BW){1'b0}}, bank_q};
      else
        hold_d = {DW{1'b1}};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q  <= RGN_NONE;
      hold_q <= {DW{1'b1}};
    end else begin
      src_q  <= src_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    case (src_q)
      RGN_WRAM: cpu_rdata = wram_rdata;
      RGN_HRAM: cpu_rdata = hram_rdata;
      default:  cpu_rdata = hold_q;
    endcase
  end
endmodule

// File: rtl/wram_map_checker.sv
module wram_map_checker
  import wram_map_pkg::*;
(
  input logic              clk,
  input logic              rst_ok,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic [PHYS_W-1:0] wram_addr,
  input logic              wram_sel,
  input logic              wram_we
);
  logic in_win, unmapped;
  assign in_win   = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
  assign unmapped = !in_win && !(cpu_addr >= HRAM_LO && cpu_addr <= HRAM_HI)
                    && (cpu_addr != BANK_ADDR);

  a_r2_sel_on_access: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_win && (cpu_rd || cpu_wr)) |-> wram_sel);
  a_r2_we_only_write: assert property (@(posedge clk) disable iff (!rst_ok)
    wram_we |-> (cpu_wr && wram_sel));
  a_r3_low_fixed: assert property (@(posedge clk) disable iff (!rst_ok)
    (wram_sel && !cpu_addr[OFS_W]) |-> (wram_addr[PHYS_W-1:OFS_W] == '0));
  a_r5_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_ok)
    (wram_sel && cpu_addr[OFS_W]) |-> (wram_addr[PHYS_W-1:OFS_W] != '0));
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_ok)
    wram_sel |-> (wram_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));
  a_r9_no_sel_outside: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_win |-> !wram_sel);
  a_r9_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_rd && unmapped) |=> (cpu_rdata == 8'hFF));
  a_r7_bank_upper_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_rd && cpu_addr == BANK_ADDR) |=> (cpu_rdata[DATA_W-1:BANK_W] == '0));
endmodule

bind banked_wram_mapper wram_map_checker u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .wram_addr (wram_addr),
  .wram_sel  (wram_sel),
  .wram_we   (wram_we)
);

// File: tb/banked_wram_mapper_tb.sv
module banked_wram_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_rdata;
  logic [14:0] wram_addr;
  logic        wram_sel, wram_we;
  logic [7:0]  wram_wdata;
  logic [7:0]  wram_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_wram_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .wram_addr(wram_addr), .wram_sel(wram_sel), .wram_we(wram_we),
    .wram_wdata(wram_wdata), .wram_rdata(wram_rdata)
  );

  // External synchronous work RAM, sparse.
  logic [7:0] ram_model [int];
  always @(posedge clk) begin
    if (wram_sel) begin
      if (wram_we) ram_model[int'(wram_addr)] = wram_wdata;
      else wram_rdata <= ram_model.exists(int'(wram_addr)) ? ram_model[int'(wram_addr)] : 8'h00;
    end
  end

  // {bank[2:0], addr[15:0], exp_sel, exp_phys[14:0]}
  localparam int NVEC = 12;
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 16'hC000, 1'b1, 15'h0000},
    {3'd0, 16'hD000, 1'b1, 15'h1000},
    {3'd0, 16'hDFFF, 1'b1, 15'h1FFF},
    {3'd1, 16'hD456, 1'b1, 15'h1456},
    {3'd3, 16'hD123, 1'b1, 15'h3123},
    {3'd7, 16'hDFFF, 1'b1, 15'h7FFF},
    {3'd7, 16'hCABC, 1'b1, 15'h0ABC},
    {3'd5, 16'hE010, 1'b1, 15'h0010},
    {3'd5, 16'hF456, 1'b1, 15'h5456},
    {3'd2, 16'hFDFF, 1'b1, 15'h2DFF},
    {3'd2, 16'hFE00, 1'b0, 15'h0000},
    {3'd2, 16'hBFFF, 1'b0, 15'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  // Drive a read and sample the combinational RAM-side outputs.
  task automatic peek(input logic [15:0] a, output logic sel, output logic [14:0] pa);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    sel = wram_sel; pa = wram_addr;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic        s;
    logic [14:0] p;
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    do_read(16'hFF70, d);
    check("R1 bank reg after reset", d, 8'h00);
    peek(16'hD234, s, p);
    check("R1 sel after reset", s, 1'b1);
    check("R1 upper half -> bank 1 after reset", p, 15'h1234);

    // Vector table: R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      do_write(16'hFF70, {5'b11111, VEC[i][34:32]});
      peek(VEC[i][31:16], s, p);
      check($sformatf("R3/R4/R5/R6 vec%0d sel", i), s, VEC[i][15]);
      if (VEC[i][15])
        check($sformatf("R3/R4/R5/R6 vec%0d phys", i), p, VEC[i][14:0]);
    end

    // R2: write strobes
    do_write(16'hFF70, 8'h03);
    @(negedge clk);
    cpu_addr = 16'hD010; cpu_wdata = 8'hA5; cpu_wr = 1'b1;
    #1;
    check("R2 sel on write", wram_sel, 1'b1);
    check("R2 we on write", wram_we, 1'b1);
    check("R2 wdata passthrough", wram_wdata, 8'hA5);
    check("R4 phys on write", wram_addr, 15'h3010);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'hC010; cpu_rd = 1'b1;
    #1;
    check("R2 no we on read", wram_we, 1'b0);
    @(negedge clk);
    cpu_rd = 1'b0;

    // R10 / R6: data through echo aliases, one-cycle latency
    do_write(16'hE123, 8'h77);
    do_read(16'hC123, d);
    check("R10 echo-low write, primary read", d, 8'h77);
    do_write(16'hF800, 8'h99);
    do_read(16'hD800, d);
    check("R10 echo-high write, primary read", d, 8'h99);
    do_read(16'hD010, d);
    check("R10 bank3 data", d, 8'hA5);
    do_write(16'hFF70, 8'h04);
    do_read(16'hD800, d);
    check("R4 other bank isolated", d, 8'h00);
    do_write(16'hFF70, 8'h00);
    do_write(16'hD800, 8'h3C);
    do_write(16'hFF70, 8'h01);
    do_read(16'hF800, d);
    check("R5 bank0 same as bank1", d, 8'h3C);

    // R7: readback of stored value including zero
    do_write(16'hFF70, 8'hFD);
    do_read(16'hFF70, d);
    check("R7 readback masks upper bits", d, 8'h05);
    do_write(16'hFF70, 8'h00);
    do_read(16'hFF70, d);
    check("R7 readback of zero", d, 8'h00);

    // R8: high RAM
    do_write(16'hFF80, 8'h11);
    do_write(16'hFFFE, 8'h22);
    do_write(16'hFFC3, 8'h33);
    peek(16'hFFC3, s, p);
    check("R8 no wram_sel for hram", s, 1'b0);
    do_read(16'hFF80, d);
    check("R8 hram first byte", d, 8'h11);
    do_read(16'hFFFE, d);
    check("R8 hram last byte", d, 8'h22);
    do_read(16'hFFC3, d);
    check("R8 hram middle byte", d, 8'h33);

    // R9: unmapped
    do_read(16'hFFFF, d);
    check("R9 read 0xFFFF", d, 8'hFF);
    do_read(16'hFF00, d);
    check("R9 read 0xFF00", d, 8'hFF);
    peek(16'h8000, s, p);
    check("R9 no sel below window", s, 1'b0);
    do_read(16'h8000, d);
    check("R9 read below window", d, 8'hFF);
    do_write(16'hFF70, 8'h02);
    do_write(16'hFFFF, 8'h07);
    do_write(16'hFF7F, 8'hAA);
    do_read(16'hFF70, d);
    check("R9 unmapped write leaves bank reg", d, 8'h02);
    do_read(16'hFF80, d);
    check("R9 unmapped write leaves hram", d, 8'h11);

    finish_run();
  end
endmodule